// File: doc/BRIEF.md
# Bus Slave Register Interface

This block is the register front end of a multi-channel analog output card sitting on an asynchronous, strobe-driven backplane bus. It decodes bus transfer requests against an 8-bit base address and moves data between the bus and its internal registers. Those registers are a fixed identification word, a control/status word, and up to twelve channel data registers. The channel registers are split into three identical groups of four. The first group is always fitted. The other two are reported through presence inputs.

Each accepted access gets exactly one acknowledge, which is released only after the master lets go of the data strobe. A write to a channel register also launches the serializer for that channel through a one-cycle start strobe. The strobe carries the channel number and the 12 significant data bits.

Reset leaves the analog outputs disconnected and the fail lamp lit, and software changes both through the control/status word. A request is refused if a bus error, another slave's acknowledge, a long-word request or an interrupt acknowledge is present when the data strobe arrives. During one address-strobe assertion the block answers only the first access of a pipelined sequence.

Top module: `bus_slave_regfile`

## Requirements
- R1: On synchronous reset, out_connect_o is 0, fail_led_o is 1, dtack_o is 0 and start_o is 0.
- R2: An access is decoded only when addr_i[12:5] equals the base 8'hC4. Offset 0 is the identification word, which reads as 16'hA0C3. Offset 1 is the control/status word. Offsets 16 to 27 are channels 0 to 11. Any other offset, and any base mismatch, gets no acknowledge.
- R3: For an accepted access, dtack_o rises once the write is captured or the read data is ready. It stays high while ds_i is held and falls one cycle after ds_i is released. Each address-strobe assertion yields at most one acknowledge.
- R4: Read data is valid on rdata_o while dtack_o is high. A channel register reads back its 12 stored bits right-justified, with bits 15:12 zero.
- R5: In the control/status word, bit 0 is the output-connect enable (1 = connected) and bit 1 is the fail lamp (1 = lit). Both are written by software and read back.
- R6: Control/status bits 2 and 3 are read-only and mirror the presence of groups 1 and 2. Bits 4+n (n = 0..11) read 1 when channel n's group is fitted, so the upper layout follows the presence inputs.
- R7: An access to a channel in an unpopulated group gets no acknowledge and no start strobe, and the stored channel data is unchanged.
- R8: If berr_i, ext_dtack_i, lword_i or iack_i is high when the data strobe is seen, the access gets no acknowledge and no register changes.
- R9: After the first access under one address-strobe assertion, further data strobes are ignored until as_i falls, even if the address changes. This means no acknowledge and no write.
- R10: A write to channel n raises start_o for exactly one cycle, in the cycle dtack_o rises. In that cycle start_chan_o = n and start_data_o = the written bits 11:0.
- R11: A write to the identification word is acknowledged but leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Address strobe, high = asserted |
| ds_i | input | 1 | Data strobe, high = asserted |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Word address: base in 12:5, offset in 4:0 |
| wdata_i | input | 16 | Write data |
| berr_i | input | 1 | Bus error line asserted |
| ext_dtack_i | input | 1 | Acknowledge from another slave asserted |
| lword_i | input | 1 | Long-word transfer requested |
| iack_i | input | 1 | Interrupt acknowledge cycle |
| grp_present_i | input | 2 | Presence of channel groups 1 and 2 |
| dtack_o | output | 1 | Data transfer acknowledge |
| rdata_o | output | 16 | Read data, zero outside a read acknowledge |
| out_connect_o | output | 1 | Analog outputs connected |
| fail_led_o | output | 1 | Fail lamp lit |
| start_o | output | 1 | One-cycle serializer start |
| start_chan_o | output | 4 | Channel index for the start |
| start_data_o | output | 12 | Data bits for the serializer |

## Verification
The bench builds the block with its default parameters: three groups of four channels, 12-bit data and base 8'hC4. This makes the full channel range 0 to 11, the first unmapped offset 28, and both optional groups reachable. Group presence is a run-time input, so the bench changes it between accesses. That brings every control/status layout within reach, along with refusal of an absent group and recovery of that group's stored data once it returns. Pipelined sequences are produced by changing the address and re-asserting the data strobe while the address strobe stays high.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } hs_state_t;

  typedef enum logic [1:0] {
    K_NONE,
    K_ID,
    K_CSR,
    K_CHAN
  } reg_kind_t;
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
  import bsr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BASE_W     = 8,
  parameter logic [BASE_W-1:0] BASE_ADDR = 8'hC4,
  parameter int GROUPS     = 3,
  parameter int CH_PER_GRP = 4,
  parameter int N_CH       = GROUPS * CH_PER_GRP,
  parameter int CH_W       = $clog2(N_CH),
  parameter int GRP_W      = $clog2(GROUPS),
  parameter int SUB_W      = $clog2(CH_PER_GRP)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GROUPS-1:0] present_i,
  output reg_kind_t         kind_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              ok_o
);
  localparam int OFF_W = ADDR_W - BASE_W;

  logic              base_hit;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-2:0]  chan_full;
  logic              grp_fitted;

  assign base_hit  = (addr_i[ADDR_W-1 -: BASE_W] == BASE_ADDR);
  assign off       = addr_i[OFF_W-1:0];
  assign chan_full = off[OFF_W-2:0];
  assign chan_o    = CH_W'(chan_full);
  assign grp_o     = GRP_W'(chan_o / CH_W'(CH_PER_GRP));
  assign sub_o     = SUB_W'(chan_o % CH_W'(CH_PER_GRP));

  always_comb begin
    kind_o = K_NONE;
    if (base_hit) begin
      if (off[OFF_W-1]) begin
        if (chan_full < (OFF_W-1)'(N_CH)) kind_o = K_CHAN;
      end else if (off == OFF_W'(0)) begin
        kind_o = K_ID;
      end else if (off == OFF_W'(1)) begin
        kind_o = K_CSR;
      end
    end
  end

  always_comb begin
    grp_fitted = 1'b0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp_o == GRP_W'(g)) grp_fitted = present_i[g];
    end
  end

  assign ok_o = (kind_o != K_NONE) && ((kind_o != K_CHAN) || grp_fitted);
endmodule

// File: rtl/bsr_handshake.sv
module bsr_handshake
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inhibit_i,
  input  logic              ok_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_q,
  output logic              access_o,
  output logic              dtack_o
);
  hs_state_t state;

  assign access_o = (state == ST_ARMED) && as_i && ds_i && !inhibit_i && ok_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      dtack_o <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (as_i) begin
            addr_q <= addr_i;
            wr_q   <= write_i;
            state  <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (!as_i) begin
            state <= ST_IDLE;
          end else if (ds_i) begin
            if (access_o) begin
              dtack_o <= 1'b1;
              state   <= ST_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (!ds_i) begin
            dtack_o <= 1'b0;
            state   <= ST_HOLD;
          end
        end
        ST_HOLD, ST_SKIP: begin
          if (!as_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_no_ack_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && ds_i && inhibit_i) |=> !dtack_o);
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (dtack_o && !ds_i) |=> !dtack_o);
  p_ack_needs_ds_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack_o) |-> $past(ds_i));
  p_first_only_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && as_i) |=> !dtack_o);
endmodule

// File: rtl/bsr_ctl_regs.sv
module bsr_ctl_regs #(
  parameter int DATA_W     = 16,
  parameter int GROUPS     = 3,
  parameter int CH_PER_GRP = 4,
  parameter int N_CH       = GROUPS * CH_PER_GRP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [GROUPS-1:0] present_i,
  output logic              connect_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] csr_o
);
  localparam int CH_BASE = GROUPS + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      connect_o <= 1'b0;
      fail_o    <= 1'b1;
    end else if (we_i) begin
      connect_o <= wdata_i[0];
      fail_o    <= wdata_i[1];
    end
  end

  always_comb begin
    csr_o    = '0;
    csr_o[0] = connect_o;
    csr_o[1] = fail_o;
    for (int g = 1; g < GROUPS; g++) csr_o[1+g] = present_i[g];
    for (int c = 0; c < N_CH; c++) csr_o[CH_BASE+c] = present_i[c/CH_PER_GRP];
  end

  p_reset_safe_r1: assert property (@(posedge clk)
    rst |=> (!connect_o && fail_o));
endmodule

// File: rtl/bsr_chan_bank.sv
module bsr_chan_bank #(
  parameter int DAC_W      = 12,
  parameter int GROUPS     = 3,
  parameter int CH_PER_GRP = 4,
  parameter int GRP_W      = $clog2(GROUPS),
  parameter int SUB_W      = $clog2(CH_PER_GRP)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [DAC_W-1:0] wdata_i,
  output logic [DAC_W-1:0] rdata_o
);
  logic [DAC_W-1:0] rq [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [DAC_W-1:0] mem [CH_PER_GRP];
    logic             sel;
    assign sel = (grp_i == GRP_W'(g));

    always_ff @(posedge clk) begin
      if (we_i && sel) mem[sub_i] <= wdata_i;
      if (re_i && sel) rq[g] <= mem[sub_i];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp_i == GRP_W'(g)) rdata_o = rq[g];
    end
  end
endmodule

// File: rtl/bus_slave_regfile.sv
module bus_slave_regfile
  import bsr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BASE_W     = 8,
  parameter logic [BASE_W-1:0] BASE_ADDR = 8'hC4,
  parameter int DATA_W     = 16,
  parameter int DAC_W      = 12,
  parameter int GROUPS     = 3,
  parameter int CH_PER_GRP = 4,
  parameter logic [DATA_W-1:0] BOARD_ID = 16'hA0C3,
  parameter int N_CH       = GROUPS * CH_PER_GRP,
  parameter int CH_W       = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              berr_i,
  input  logic              ext_dtack_i,
  input  logic              lword_i,
  input  logic              iack_i,
  input  logic [GROUPS-2:0] grp_present_i,
  output logic              dtack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              out_connect_o,
  output logic              fail_led_o,
  output logic              start_o,
  output logic [CH_W-1:0]   start_chan_o,
  output logic [DAC_W-1:0]  start_data_o
);
  localparam int GRP_W = $clog2(GROUPS);
  localparam int SUB_W = $clog2(CH_PER_GRP);

  logic [GROUPS-1:0] present;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic              access;
  logic              inhibit;
  reg_kind_t         kind;
  logic [CH_W-1:0]   chan;
  logic [GRP_W-1:0]  grp;
  logic [SUB_W-1:0]  sub;
  logic              ok;
  logic              we_csr, we_ch, re_ch;
  logic [DATA_W-1:0] csr_val;
  logic [DATA_W-1:0] ctl_rd_q;
  logic [DAC_W-1:0]  ch_rd;

  assign present = {grp_present_i, 1'b1};
  assign inhibit = berr_i | ext_dtack_i | lword_i | iack_i;

  bsr_handshake #(.ADDR_W(ADDR_W)) u_hs (
    .clk(clk), .rst(rst), .as_i(as_i), .ds_i(ds_i), .write_i(write_i),
    .addr_i(addr_i), .inhibit_i(inhibit), .ok_i(ok),
    .addr_q(addr_q), .wr_q(wr_q), .access_o(access), .dtack_o(dtack_o)
  );

  bsr_decode #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .BASE_ADDR(BASE_ADDR),
    .GROUPS(GROUPS), .CH_PER_GRP(CH_PER_GRP), .N_CH(N_CH),
    .CH_W(CH_W), .GRP_W(GRP_W), .SUB_W(SUB_W)
  ) u_dec (
    .addr_i(addr_q), .present_i(present), .kind_o(kind),
    .chan_o(chan), .grp_o(grp), .sub_o(sub), .ok_o(ok)
  );

  assign we_csr = access &&  wr_q && (kind == K_CSR);
  assign we_ch  = access &&  wr_q && (kind == K_CHAN);
  assign re_ch  = access && !wr_q && (kind == K_CHAN);

  bsr_ctl_regs #(
    .DATA_W(DATA_W), .GROUPS(GROUPS), .CH_PER_GRP(CH_PER_GRP), .N_CH(N_CH)
  ) u_ctl (
    .clk(clk), .rst(rst), .we_i(we_csr), .wdata_i(wdata_i),
    .present_i(present), .connect_o(out_connect_o), .fail_o(fail_led_o),
    .csr_o(csr_val)
  );

  bsr_chan_bank #(
    .DAC_W(DAC_W), .GROUPS(GROUPS), .CH_PER_GRP(CH_PER_GRP),
    .GRP_W(GRP_W), .SUB_W(SUB_W)
  ) u_bank (
    .clk(clk), .we_i(we_ch), .re_i(re_ch), .grp_i(grp), .sub_i(sub),
    .wdata_i(wdata_i[DAC_W-1:0]), .rdata_o(ch_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rd_q <= '0;
    end else if (access && !wr_q) begin
      ctl_rd_q <= (kind == K_ID) ? BOARD_ID : csr_val;
    end
  end

  assign rdata_o = (dtack_o && !wr_q)
                 ? ((kind == K_CHAN) ? {{(DATA_W-DAC_W){1'b0}}, ch_rd} : ctl_rd_q)
                 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o      <= 1'b0;
      start_chan_o <= '0;
      start_data_o <= '0;
    end else begin
      start_o <= we_ch;
      if (we_ch) begin
        start_chan_o <= chan;
        start_data_o <= wdata_i[DAC_W-1:0];
      end
    end
  end

  p_start_with_ack_r10: assert property (@(posedge clk) disable iff (rst)
    start_o |-> dtack_o);
  p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !dtack_o |-> (rdata_o == '0));
endmodule

// File: tb/sim_bus_slave_regfile.sv
module sim_bus_slave_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        as_i = 0, ds_i = 0, write_i = 0;
  logic [12:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        berr_i = 0, ext_dtack_i = 0, lword_i = 0, iack_i = 0;
  logic [1:0]  grp_present_i = 2'b11;
  logic        dtack_o;
  logic [15:0] rdata_o;
  logic        out_connect_o, fail_led_o, start_o;
  logic [3:0]  start_chan_o;
  logic [11:0] start_data_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic        r_ack, r_start, r_held, r_rel;
  logic [15:0] r_data;
  logic [3:0]  r_chan;
  logic [11:0] r_sdata;

  always #5 clk = ~clk;

  bus_slave_regfile u0 (
    .clk(clk), .rst(rst), .as_i(as_i), .ds_i(ds_i), .write_i(write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .berr_i(berr_i),
    .ext_dtack_i(ext_dtack_i), .lword_i(lword_i), .iack_i(iack_i),
    .grp_present_i(grp_present_i), .dtack_o(dtack_o), .rdata_o(rdata_o),
    .out_connect_o(out_connect_o), .fail_led_o(fail_led_o),
    .start_o(start_o), .start_chan_o(start_chan_o), .start_data_o(start_data_o)
  );

  function automatic logic [12:0] adr(input logic [4:0] off);
    return {8'hC4, off};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One complete bus access; results land in r_* variables.
  task automatic access(input logic wr, input logic [12:0] a, input logic [15:0] d);
    r_ack = 0; r_start = 0; r_held = 0; r_rel = 0; r_data = '0; r_chan = '0; r_sdata = '0;
    @(negedge clk); as_i = 1; addr_i = a; write_i = wr; wdata_i = d;
    @(negedge clk); ds_i = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (start_o) r_start = 1;
      if (dtack_o) begin
        r_ack = 1; r_data = rdata_o; r_chan = start_chan_o; r_sdata = start_data_o;
        break;
      end
    end
    if (r_ack) begin
      @(negedge clk); r_held = dtack_o && !start_o;
      ds_i = 0;
      @(negedge clk); r_rel = !dtack_o;
    end else begin
      ds_i = 0;
      @(negedge clk);
    end
    as_i = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!dtack_o, "R1 dtack", 32'(dtack_o), 0);
    chk(!out_connect_o, "R1 connect", 32'(out_connect_o), 0);
    chk(fail_led_o, "R1 fail", 32'(fail_led_o), 1);
    chk(!start_o, "R1 start", 32'(start_o), 0);
  endtask

  task automatic t_id;
    access(0, adr(5'd0), '0);
    chk(r_ack && r_data == 16'hA0C3, "R2 id read", 32'(r_data), 32'hA0C3);
    access(1, adr(5'd0), 16'h5555);
    chk(r_ack && !r_start, "R11 id write acked", 32'(r_ack), 1);
    access(0, adr(5'd0), '0);
    chk(r_data == 16'hA0C3, "R11 id unchanged", 32'(r_data), 32'hA0C3);
  endtask

  task automatic t_csr;
    grp_present_i = 2'b11;
    access(0, adr(5'd1), '0);
    chk(r_data == 16'hFFFE, "R6 csr full layout", 32'(r_data), 32'hFFFE);
    access(1, adr(5'd1), 16'h0001);
    chk(out_connect_o && !fail_led_o, "R5 connect/fail write",
        32'({out_connect_o, fail_led_o}), 32'b10);
    access(0, adr(5'd1), '0);
    chk(r_data == 16'hFFFD, "R5 csr readback", 32'(r_data), 32'hFFFD);
    grp_present_i = 2'b01;
    access(0, adr(5'd1), '0);
    chk(r_data == 16'h0FF5, "R6 csr partial layout", 32'(r_data), 32'h0FF5);
    grp_present_i = 2'b11;
  endtask

  task automatic t_chan;
    access(1, adr(5'd16), 16'hF123);
    chk(r_ack && r_start && r_chan == 4'd0 && r_sdata == 12'h123, "R10 start ch0",
        32'({r_start, r_chan, r_sdata}), 32'({1'b1, 4'd0, 12'h123}));
    chk(r_held && r_rel, "R3 hold then release", 32'({r_held, r_rel}), 32'b11);
    access(0, adr(5'd16), '0);
    chk(r_ack && r_data == 16'h0123, "R4 ch0 readback", 32'(r_data), 32'h0123);
    chk(!r_start, "R10 no start on read", 32'(r_start), 0);
    access(1, adr(5'd27), 16'h0ABC);
    chk(r_start && r_chan == 4'd11 && r_sdata == 12'hABC, "R10 start ch11",
        32'({r_chan, r_sdata}), 32'({4'd11, 12'hABC}));
    access(0, adr(5'd27), '0);
    chk(r_data == 16'h0ABC, "R4 ch11 readback", 32'(r_data), 32'h0ABC);
  endtask

  task automatic t_decode;
    access(0, {8'hC5, 5'd16}, '0);
    chk(!r_ack, "R2 base mismatch", 32'(r_ack), 0);
    access(0, adr(5'd2), '0);
    chk(!r_ack, "R2 unmapped offset 2", 32'(r_ack), 0);
    access(1, adr(5'd28), 16'h0001);
    chk(!r_ack && !r_start, "R2 offset past ch11", 32'(r_ack), 0);
  endtask

  task automatic t_unpop;
    grp_present_i = 2'b11;
    access(1, adr(5'd25), 16'h0456);
    grp_present_i = 2'b01;
    access(1, adr(5'd25), 16'h0999);
    chk(!r_ack && !r_start, "R7 absent group write", 32'({r_ack, r_start}), 0);
    access(0, adr(5'd25), '0);
    chk(!r_ack, "R7 absent group read", 32'(r_ack), 0);
    access(0, adr(5'd20), '0);
    chk(r_ack, "R7 group1 still fitted", 32'(r_ack), 1);
    grp_present_i = 2'b11;
    access(0, adr(5'd25), '0);
    chk(r_data == 16'h0456, "R7 data kept", 32'(r_data), 32'h0456);
  endtask

  task automatic t_inhibit;
    access(1, adr(5'd17), 16'h0111);
    for (int k = 0; k < 4; k++) begin
      berr_i = (k == 0); ext_dtack_i = (k == 1); lword_i = (k == 2); iack_i = (k == 3);
      access(1, adr(5'd17), 16'h0321);
      chk(!r_ack && !r_start, $sformatf("R8 inhibit line %0d", k), 32'(r_ack), 0);
      berr_i = 0; ext_dtack_i = 0; lword_i = 0; iack_i = 0;
    end
    access(0, adr(5'd17), '0);
    chk(r_data == 16'h0111, "R8 data unchanged", 32'(r_data), 32'h0111);
  endtask

  task automatic t_pipeline;
    logic seen_ack, seen_start;
    access(1, adr(5'd19), 16'h0003);
    @(negedge clk); as_i = 1; addr_i = adr(5'd18); write_i = 1; wdata_i = 16'h0222;
    @(negedge clk); ds_i = 1;
    seen_ack = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dtack_o) begin seen_ack = 1; break; end
    end
    chk(seen_ack, "R9 first access answered", 32'(seen_ack), 1);
    @(negedge clk); ds_i = 0;
    @(negedge clk); addr_i = adr(5'd19); wdata_i = 16'h0333;
    @(negedge clk); ds_i = 1;
    seen_ack = 0; seen_start = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dtack_o) seen_ack = 1;
      if (start_o) seen_start = 1;
    end
    chk(!seen_ack && !seen_start, "R9 second access ignored",
        32'({seen_ack, seen_start}), 0);
    ds_i = 0;
    @(negedge clk); as_i = 0;
    @(negedge clk);
    access(0, adr(5'd19), '0);
    chk(r_data == 16'h0003, "R9 second write dropped", 32'(r_data), 32'h0003);
    access(0, adr(5'd18), '0);
    chk(r_data == 16'h0222, "R9 first write kept", 32'(r_data), 32'h0222);
  endtask

  task automatic t_rereset;
    access(1, adr(5'd1), 16'h0001);
    chk(out_connect_o, "R5 connected before reset", 32'(out_connect_o), 1);
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    chk(!out_connect_o && fail_led_o, "R1 reset disconnects",
        32'({out_connect_o, fail_led_o}), 32'b01);
    rst = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_id();
    t_csr();
    t_chan();
    t_decode();
    t_unpop();
    t_inhibit();
    t_pipeline();
    t_rereset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule